// File: doc/BRIEF.md
# Pointer Address Generator with Circular Wrap

This combinational block serves the load/store path of a processor core. Each operation supplies a pointer value, the index of the register that holds it, a displacement and an addressing mode. The block returns the effective memory address and the updated pointer value. It also returns a write-back enable, which tells the register file whether to store that updated pointer.

Eight pointer registers can be set to wrap inside a buffer instead of counting linearly. These are entries 4 to 7 of side A and entries 4 to 7 of side B. A 32-bit mode control word holds one 2-bit field per wrap-capable register and two 5-bit block-size codes. When wrapping is in force, only the low N+1 bits of the pointer move, so the pointer stays inside an aligned buffer of 2^(N+1) bytes. The buffer can be walked in either direction without any software bounds check.

Top module: `ptr_agen`

## Requirements
- R1: Mode code 0 (indirect) sets `eff_addr` to `ptr_in` and `wb_en` to 0. Codes 6 and 7 are unused and behave the same way.
- R2: Mode code 1 (use, then add) sets `eff_addr` to `ptr_in`, sets `ptr_new` to `ptr_in` plus d, and sets `wb_en` to 1.
- R3: Mode code 2 (use, then subtract) sets `eff_addr` to `ptr_in`, sets `ptr_new` to `ptr_in` minus d, and sets `wb_en` to 1.
- R4: Mode codes 3 (add first) and 4 (subtract first) set both `eff_addr` and `ptr_new` to `ptr_in` plus or minus d, and set `wb_en` to 1.
- R5: Mode code 5 (offset) sets `eff_addr` to `ptr_in` plus d, leaves `ptr_new` equal to `ptr_in`, and sets `wb_en` to 0.
- R6: When `disp_dflt` is 1, d is 1 and `disp` is ignored. Otherwise d is `disp`, zero-extended.
- R7: `ptr_idx` bit 4 selects side B and bits 3:0 give the register number. For register numbers 4 to 7, the mode field is `mode_word[2*(num-4)+1 : 2*(num-4)]` on side A, and the same position plus 8 on side B. Field value 01 selects wrap with size code 0, 10 selects wrap with size code 1, and 00 or 11 selects linear.
- R8: Size code 0 is `mode_word[20:16]` and size code 1 is `mode_word[25:21]`. A code value N gives a buffer of 2^(N+1) bytes.
- R9: In wrap mode, stepping past the last byte of the buffer continues from its first byte. Bits above bit N of the address are left unchanged.
- R10: In wrap mode, stepping below the first byte of the buffer continues from its last byte.
- R11: Register numbers outside 4 to 7 always address linearly, whatever `mode_word` holds.
- R12: In offset mode, a wrap-enabled register also wraps the effective address inside its buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ptr_in | input | 32 | Current pointer value |
| ptr_idx | input | 5 | Pointer register index: bit 4 is the side, bits 3:0 are the number |
| disp | input | 16 | Unsigned displacement in bytes |
| disp_dflt | input | 1 | Use a displacement of 1 instead of `disp` |
| amode | input | 3 | Addressing mode code |
| mode_word | input | 32 | Wrap mode fields and buffer size codes |
| eff_addr | output | 32 | Effective memory address |
| ptr_new | output | 32 | Pointer value to write back |
| wb_en | output | 1 | Write-back enable for `ptr_new` |

## Verification
The assertions re-check several relations whenever an input changes. Modes with no update never raise write-back. The add-first and subtract-first modes return the same value on both outputs. The use-then-step modes address with the unmodified pointer. A wrapped result never differs from the pointer above the buffer's size bits. Some behaviour only the bench's directed scenarios can show: the actual arithmetic values, the correct choice of field and size code for each register index, wrapping up and down at the buffer edges, and the fact that registers outside the wrap-capable set ignore the control word.

// File: rtl/agen_pkg.sv
package agen_pkg;
  localparam int AGEN_MW = 3;

  typedef enum logic [AGEN_MW-1:0] {
    AM_IND     = 3'd0,
    AM_POSTINC = 3'd1,
    AM_POSTDEC = 3'd2,
    AM_PREINC  = 3'd3,
    AM_PREDEC  = 3'd4,
    AM_OFFSET  = 3'd5
  } agen_mode_e;

  localparam int SZ_W    = 5;
  localparam int SZ0_LSB = 16;
  localparam int SZ1_LSB = SZ0_LSB + SZ_W;

  // Mask covering the low n+1 bits of a w-bit address.
  function automatic logic [63:0] blk_mask(input logic [SZ_W-1:0] n, input int w);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < 64; i++)
      m[i] = (i < w) && (i <= int'(n));
    return m;
  endfunction

  // Add a two's-complement delta, letting only the masked bits move.
  function automatic logic [63:0] wrap_step(input logic [63:0] base, input logic [63:0] delta,
                                            input logic [63:0] mask, input logic circ);
    logic [63:0] lin;
    lin = base + delta;
    return circ ? ((base & ~mask) | (lin & mask)) : lin;
  endfunction
endpackage

// File: rtl/agen_circ_decode.sv
module agen_circ_decode
  import agen_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int CW    = 32
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [CW-1:0]    ctrl,
  output logic             circ,
  output logic [SZ_W-1:0]  nsel
);
  logic [3:0] num;
  logic       capable;
  logic [1:0] field;
  logic [3:0] fpos;

  assign num     = idx[3:0];
  assign capable = (num >= 4'd4) && (num <= 4'd7);
  assign fpos    = {idx[IDX_W-1], num[1:0], 1'b0};
  assign field   = ctrl[fpos +: 2];

  always_comb begin
    circ = 1'b0;
    nsel = ctrl[SZ0_LSB +: SZ_W];
    if (capable) begin
      case (field)
        2'b01: begin circ = 1'b1; nsel = ctrl[SZ0_LSB +: SZ_W]; end
        2'b10: begin circ = 1'b1; nsel = ctrl[SZ1_LSB +: SZ_W]; end
        default: circ = 1'b0;
      endcase
    end
  end

  always_comb begin
    p_circ_capable_r11 : assert (!circ || capable) else $error("wrap on non-capable register");
  end
endmodule

// File: rtl/agen_step.sv
module agen_step
  import agen_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0]   base,
  input  logic [AW-1:0]   delta,
  input  logic            circ,
  input  logic [SZ_W-1:0] nsel,
  output logic [AW-1:0]   res
);
  logic [63:0] mask64;
  logic [63:0] res64;
  logic [AW-1:0] hi_mask;

  assign mask64  = blk_mask(nsel, AW);
  assign res64   = wrap_step(64'(base), {{(64-AW){delta[AW-1]}}, delta}, mask64, circ);
  assign res     = res64[AW-1:0];
  assign hi_mask = ~mask64[AW-1:0];

  always_comb begin
    p_wrap_keeps_high_r9 : assert (!circ || ((res & hi_mask) == (base & hi_mask)))
      else $error("wrap disturbed bits above buffer size");
  end
endmodule

// File: rtl/ptr_agen.sv
module ptr_agen
  import agen_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 16,
  parameter int IDX_W = 5,
  parameter int CW    = 32
) (
  input  logic [AW-1:0]      ptr_in,
  input  logic [IDX_W-1:0]   ptr_idx,
  input  logic [DW-1:0]      disp,
  input  logic               disp_dflt,
  input  logic [AGEN_MW-1:0] amode,
  input  logic [CW-1:0]      mode_word,
  output logic [AW-1:0]      eff_addr,
  output logic [AW-1:0]      ptr_new,
  output logic               wb_en
);
  logic [AW-1:0]   d_ext;
  logic [AW-1:0]   delta;
  logic            step_neg;
  logic            circ_act;
  logic [SZ_W-1:0] size_code;
  logic [AW-1:0]   stepped;
  logic            is_post, is_pre, is_off;

  assign d_ext    = disp_dflt ? AW'(1) : AW'(disp);
  assign step_neg = (amode == AM_POSTDEC) || (amode == AM_PREDEC);
  assign delta    = step_neg ? (~d_ext + AW'(1)) : d_ext;
  assign is_post  = (amode == AM_POSTINC) || (amode == AM_POSTDEC);
  assign is_pre   = (amode == AM_PREINC)  || (amode == AM_PREDEC);
  assign is_off   = (amode == AM_OFFSET);

  agen_circ_decode #(.IDX_W(IDX_W), .CW(CW)) u_dec (
    .idx  (ptr_idx),
    .ctrl (mode_word),
    .circ (circ_act),
    .nsel (size_code)
  );

  agen_step #(.AW(AW)) u_step (
    .base  (ptr_in),
    .delta (delta),
    .circ  (circ_act),
    .nsel  (size_code),
    .res   (stepped)
  );

  always_comb begin
    eff_addr = ptr_in;
    ptr_new  = ptr_in;
    wb_en    = 1'b0;
    if (is_post) begin
      ptr_new = stepped;
      wb_en   = 1'b1;
    end else if (is_pre) begin
      eff_addr = stepped;
      ptr_new  = stepped;
      wb_en    = 1'b1;
    end else if (is_off) begin
      eff_addr = stepped;
    end
  end

  always_comb begin
    p_ind_nowb_r1 : assert (amode != AM_IND || (!wb_en && eff_addr == ptr_in))
      else $error("indirect mode altered pointer");
    p_post_addr_r2 : assert (!is_post || (eff_addr == ptr_in && wb_en))
      else $error("post mode address wrong");
    p_pre_same_r4 : assert (!is_pre || (eff_addr == ptr_new && wb_en))
      else $error("pre mode outputs differ");
    p_off_nowb_r5 : assert (!is_off || (!wb_en && ptr_new == ptr_in))
      else $error("offset mode wrote back");
  end
endmodule

// File: tb/tb_ptr_agen.sv
module tb_ptr_agen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ptr_in;
  logic [4:0]  ptr_idx;
  logic [15:0] disp;
  logic        disp_dflt;
  logic [2:0]  amode;
  logic [31:0] mode_word;
  logic [31:0] eff_addr, ptr_new;
  logic        wb_en;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptr_agen dut (
    .ptr_in(ptr_in), .ptr_idx(ptr_idx), .disp(disp), .disp_dflt(disp_dflt),
    .amode(amode), .mode_word(mode_word),
    .eff_addr(eff_addr), .ptr_new(ptr_new), .wb_en(wb_en)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Independent restatement: buffer of 2^(n+1) bytes, offset taken modulo size.
  function automatic logic [31:0] circ_exp(input logic [31:0] r, input longint dlt, input int n);
    longint sz, lo, t;
    sz = longint'(1) << (n + 1);
    lo = longint'(r) % sz;
    t = (lo + dlt) % sz;
    if (t < 0) t += sz;
    return 32'(longint'(r) - lo + t);
  endfunction

  task automatic apply(input logic [31:0] p, input logic [4:0] ix, input logic [15:0] d,
                       input logic df, input logic [2:0] m, input logic [31:0] mw);
    @(negedge clk);
    ptr_in = p; ptr_idx = ix; disp = d; disp_dflt = df; amode = m; mode_word = mw;
    #1;
  endtask

  task automatic t_idle;
    apply(32'h0, 5'd0, 16'd0, 1'b0, 3'd0, 32'h0);
    chk("R1", "idle ea", eff_addr, 32'h0);
    chk("R1", "idle wb", 32'(wb_en), 32'd0);
  endtask

  task automatic t_indirect;
    apply(32'h0000_1000, 5'd2, 16'd8, 1'b0, 3'd0, 32'h0);
    chk("R1", "ind ea", eff_addr, 32'h1000);
    chk("R1", "ind wb", 32'(wb_en), 32'd0);
    apply(32'h0000_1000, 5'd2, 16'd8, 1'b0, 3'd7, 32'h0);
    chk("R1", "code7 ea", eff_addr, 32'h1000);
    chk("R1", "code7 wb", 32'(wb_en), 32'd0);
  endtask

  task automatic t_post;
    apply(32'h0000_1000, 5'd1, 16'd8, 1'b0, 3'd1, 32'h0);
    chk("R2", "postinc ea", eff_addr, 32'h1000);
    chk("R2", "postinc new", ptr_new, 32'h1008);
    chk("R2", "postinc wb", 32'(wb_en), 32'd1);
    apply(32'h0000_1000, 5'd17, 16'd8, 1'b0, 3'd2, 32'h0);
    chk("R3", "postdec ea", eff_addr, 32'h1000);
    chk("R3", "postdec new", ptr_new, 32'h0FF8);
    chk("R3", "postdec wb", 32'(wb_en), 32'd1);
  endtask

  task automatic t_pre;
    apply(32'h0000_0004, 5'd9, 16'd12, 1'b0, 3'd3, 32'h0);
    chk("R4", "preinc ea", eff_addr, 32'h10);
    chk("R4", "preinc new", ptr_new, 32'h10);
    apply(32'h0000_0004, 5'd9, 16'd12, 1'b0, 3'd4, 32'h0);
    chk("R4", "predec ea", eff_addr, 32'hFFFF_FFF8);
    chk("R4", "predec wb", 32'(wb_en), 32'd1);
  endtask

  task automatic t_offset;
    apply(32'h0000_2000, 5'd10, 16'h0100, 1'b0, 3'd5, 32'h0);
    chk("R5", "offset ea", eff_addr, 32'h2100);
    chk("R5", "offset new", ptr_new, 32'h2000);
    chk("R5", "offset wb", 32'(wb_en), 32'd0);
  endtask

  task automatic t_default;
    apply(32'h0000_3000, 5'd0, 16'h0055, 1'b1, 3'd1, 32'h0);
    chk("R6", "default d new", ptr_new, 32'h3001);
    apply(32'h0000_3000, 5'd0, 16'hFFFF, 1'b0, 3'd3, 32'h0);
    chk("R6", "full disp", eff_addr, 32'h0001_2FFF);
  endtask

  task automatic t_wrap_bk0;
    logic [31:0] mw;
    mw = 32'h0005_0004; // A5 field=01, size code 0 = 5 (64 bytes)
    apply(32'h2000_003C, 5'd5, 16'd4, 1'b0, 3'd1, mw);
    chk("R9", "bk0 wrap up", ptr_new, 32'h2000_0000);
    chk("R7", "bk0 vs model", ptr_new, circ_exp(32'h2000_003C, 4, 5));
    apply(32'h2000_0000, 5'd5, 16'd4, 1'b0, 3'd4, mw);
    chk("R10", "bk0 wrap down", eff_addr, 32'h2000_003C);
    apply(32'h2000_0010, 5'd5, 16'd200, 1'b0, 3'd2, mw);
    chk("R10", "large step down", ptr_new, circ_exp(32'h2000_0010, -200, 5));
    apply(32'h2000_003C, 5'd5, 16'd8, 1'b0, 3'd5, mw);
    chk("R12", "offset wrap ea", eff_addr, 32'h2000_0004);
    chk("R12", "offset wrap new", ptr_new, 32'h2000_003C);
  endtask

  task automatic t_wrap_bk1;
    logic [31:0] mw;
    mw = (32'd2 << 21) | (32'd7 << 16) | (32'd2 << 12); // B6 field=10, size code 1 = 2
    apply(32'h0100_0006, 5'd22, 16'd4, 1'b0, 3'd1, mw);
    chk("R8", "bk1 size 8", ptr_new, 32'h0100_0002);
    chk("R9", "bk1 high kept", ptr_new, circ_exp(32'h0100_0006, 4, 2));
  endtask

  task automatic t_ignored;
    apply(32'h0000_003C, 5'd3, 16'd4, 1'b0, 3'd1, 32'hFFFF_FFFF);
    chk("R11", "A3 linear", ptr_new, 32'h40);
    apply(32'h0000_003C, 5'd24, 16'd4, 1'b0, 3'd1, 32'hFFFF_FFFF);
    chk("R11", "B8 linear", ptr_new, 32'h40);
    apply(32'h0000_003C, 5'd4, 16'd4, 1'b0, 3'd1, 32'h0005_0003);
    chk("R7", "field 11 linear", ptr_new, 32'h40);
    apply(32'h0000_003C, 5'd4, 16'd4, 1'b0, 3'd1, 32'h0005_0004);
    chk("R7", "A4 not A5 field", ptr_new, 32'h40);
    apply(32'h0000_003C, 5'd20, 16'd4, 1'b0, 3'd1, 32'h0005_0001);
    chk("R7", "B4 ignores A4 field", ptr_new, 32'h40);
    apply(32'h0000_003C, 5'd20, 16'd4, 1'b0, 3'd1, 32'h0005_0100);
    chk("R7", "B4 own field", ptr_new, 32'h0);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    ptr_in = '0; ptr_idx = '0; disp = '0; disp_dflt = 1'b0; amode = '0; mode_word = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_idle();
    t_indirect();
    t_post();
    t_pre();
    t_offset();
    t_default();
    t_wrap_bk0();
    t_wrap_bk1();
    t_ignored();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule